// File: doc/BRIEF.md
# Programmable Half-Duty Clock Divider

This block divides a fast input clock by any whole number from 2 to 63 and keeps the output high for exactly half of each output period, whether the ratio is even or odd. For odd ratios, a counter clocked on the rising edge is combined with a copy of its high-phase flag that is retimed on the falling edge. That retimed copy adds the missing half input cycle to the high phase. A special ratio code passes the input clock straight through, and the block only accepts that code when the full-chip mode input is set.

A ratio write is not applied at once. The new value waits in a holding register and replaces the running ratio on the fifth rising input edge after the edge that captured the write. The counter then restarts from zero. Two ratios, 4 and 5, also need a realignment strobe once they have been applied. Until that strobe arrives, the output is held low. The same applies after the power-down input has been high, because the divider phase is lost while the source is idle. A ready output reports when the requested ratio is running and aligned.

Top module: `halfduty_div`

## Requirements
- R1: For a running ratio N in 2..63, `clk_out` has a period of exactly N input clock periods.
- R2: For every ratio N in 2..63, `clk_out` stays high for exactly N input half-periods in each output period, which is 50% duty, odd N included.
- R3: An accepted write sampled on rising edge E0 becomes the running ratio at edge E5. `ratio_ready` is low after edges E1 through E4 and, for ratios other than 4 and 5, high after E5.
- R4: A write whose value is 1, or whose value is 0 while `full_chip` is low, is ignored: `ratio_ready` stays high and the output period does not change.
- R5: Writing code 0 while `full_chip` is high selects bypass: once applied, `clk_out` follows `clk_in`, high for one half-period and low for the next.
- R6: After ratio 4 or 5 is applied, `clk_out` stays low and `ratio_ready` stays low until a `resync` pulse. After the pulse, the output divides correctly and `ratio_ready` is high.
- R7: While `pwr_dn` is high, `clk_out` is low. After `pwr_dn` is released, ratios 4 and 5 stay silent with `ratio_ready` low until a new `resync`. Other ratios resume without one.
- R8: While `rst_n` is low at a rising edge, `clk_out` is low. After reset, the running ratio is 2 and `ratio_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| full_chip | input | 1 | Mode flag; the bypass code is accepted only when high |
| cfg_wr | input | 1 | One-cycle strobe that writes `cfg_ratio` |
| cfg_ratio | input | 6 | Requested ratio: 2..63, or 0 for bypass |
| resync | input | 1 | Realignment strobe; restarts the counter phase |
| pwr_dn | input | 1 | Source idle; holds the output low and drops alignment |
| clk_out | output | 1 | Divided clock |
| ratio_ready | output | 1 | High when the requested ratio is running and aligned |

## Verification
The assertions assume that `cfg_wr`, `resync` and `pwr_dn` are synchronous to `clk_in` and change only between rising edges. The stimulus meets this by driving every input on the falling edge. The settle-window property also assumes that no second write arrives while a write is still pending. The bench therefore always waits for the apply edge, or longer, before the next write. The bench sweeps every ratio from 2 to 63 and bypass, and measures high time and period in half-cycle samples taken shortly after each clock edge.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int BYP_CODE  = 0;
  localparam int RATIO_MIN = 2;

  // write value accepted as a ratio or as bypass
  function automatic logic ratio_ok(input int r, input logic fc, input int rmax);
    return ((r >= RATIO_MIN) && (r <= rmax)) || ((r == BYP_CODE) && fc);
  endfunction

  // ratios whose divider needs a realignment strobe
  function automatic logic needs_sync(input int r);
    return (r == 4) || (r == 5);
  endfunction

  // rising-edge cycles the output spends high (floor of N/2)
  function automatic int high_len(input int r);
    return r / 2;
  endfunction

  function automatic logic is_odd(input int r);
    return (r % 2) == 1;
  endfunction
endpackage

// File: rtl/hd_ratio_ctrl.sv
module hd_ratio_ctrl #(
  parameter int RW        = 6,
  parameter int SETTLE    = 5,
  parameter int DEF_RATIO = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_chip,
  input  logic          cfg_wr,
  input  logic [RW-1:0] cfg_ratio,
  input  logic          resync,
  input  logic          pwr_dn,
  output logic          accept,
  output logic          apply,
  output logic          pending_q,
  output logic [RW-1:0] act_q,
  output logic [RW-1:0] act_nxt,
  output logic          synced_q,
  output logic          synced_nxt
);
  import hd_pkg::*;
  localparam int RMAX = (1 << RW) - 1;
  localparam int SW   = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);
  localparam logic [SW-1:0] ONE_V    = SW'(1);

  logic [RW-1:0] pend_q;
  logic [SW-1:0] settle_q;

  always_comb begin
    accept  = cfg_wr && ratio_ok(int'(cfg_ratio), full_chip, RMAX);
    apply   = pending_q && (settle_q == ONE_V);
    act_nxt = apply ? pend_q : act_q;
    if (pwr_dn || apply)
      synced_nxt = 1'b0;
    else if (resync)
      synced_nxt = 1'b1;
    else
      synced_nxt = synced_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= RW'(DEF_RATIO);
      pend_q    <= RW'(DEF_RATIO);
      pending_q <= 1'b0;
      settle_q  <= '0;
      synced_q  <= 1'b0;
    end else begin
      act_q    <= act_nxt;
      synced_q <= synced_nxt;
      if (accept) begin
        pend_q    <= cfg_ratio;
        settle_q  <= SETTLE_V;
        pending_q <= 1'b1;
      end else if (pending_q) begin
        settle_q <= settle_q - ONE_V;
        if (apply)
          pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hd_div_core.sv
module hd_div_core #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  input  logic          restart,
  input  logic          run,
  output logic [RW-1:0] cnt_q,
  output logic          pos_q,
  output logic          neg_q
);
  import hd_pkg::*;
  logic [RW-1:0] cnt_nxt;

  always_comb begin
    if (restart || !run)
      cnt_nxt = '0;
    else if (int'(cnt_q) >= int'(ratio) - 1)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pos_q <= run && (int'(cnt_nxt) < high_len(int'(ratio)));
    end
  end

  // half-cycle retimed copy that stretches the high phase for odd ratios
  always_ff @(negedge clk) begin
    if (!rst_n)
      neg_q <= 1'b0;
    else
      neg_q <= pos_q;
  end
endmodule

// File: rtl/halfduty_div.sv
module halfduty_div #(
  parameter int RW        = 6,
  parameter int SETTLE    = 5,
  parameter int DEF_RATIO = 2
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          full_chip,
  input  logic          cfg_wr,
  input  logic [RW-1:0] cfg_ratio,
  input  logic          resync,
  input  logic          pwr_dn,
  output logic          clk_out,
  output logic          ratio_ready
);
  import hd_pkg::*;

  logic          accept, apply, pending_q, synced_q, synced_nxt;
  logic [RW-1:0] act_q, act_nxt, cnt_q;
  logic          pos_q, neg_q;
  logic          restart, run, bypass_q, odd_q;

  hd_ratio_ctrl #(.RW(RW), .SETTLE(SETTLE), .DEF_RATIO(DEF_RATIO)) ctrl_i (
    .clk(clk_in), .rst_n(rst_n), .full_chip(full_chip), .cfg_wr(cfg_wr),
    .cfg_ratio(cfg_ratio), .resync(resync), .pwr_dn(pwr_dn),
    .accept(accept), .apply(apply), .pending_q(pending_q),
    .act_q(act_q), .act_nxt(act_nxt), .synced_q(synced_q),
    .synced_nxt(synced_nxt)
  );

  always_comb begin
    restart = apply || (resync && !pwr_dn) || pwr_dn;
    run     = !pwr_dn && (int'(act_nxt) != BYP_CODE) &&
              !(needs_sync(int'(act_nxt)) && !synced_nxt);
  end

  hd_div_core #(.RW(RW)) core_i (
    .clk(clk_in), .rst_n(rst_n), .ratio(act_nxt), .restart(restart),
    .run(run), .cnt_q(cnt_q), .pos_q(pos_q), .neg_q(neg_q)
  );

  always_comb begin
    bypass_q    = (int'(act_q) == BYP_CODE) && !pwr_dn;
    odd_q       = is_odd(int'(act_q));
    ratio_ready = !pending_q && (!needs_sync(int'(act_q)) || synced_q);
    if (bypass_q)
      clk_out = clk_in;
    else if (odd_q)
      clk_out = pos_q | neg_q;
    else
      clk_out = pos_q;
  end
endmodule

// File: rtl/hd_chk.sv
module hd_chk #(
  parameter int RW     = 6,
  parameter int SETTLE = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          apply,
  input logic          pending_q,
  input logic          pwr_dn,
  input logic          synced_q,
  input logic [RW-1:0] act_q,
  input logic [RW-1:0] cnt_q,
  input logic          pos_q,
  input logic          ratio_ready
);
  int since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_wr <= 0;
    else if (accept)
      since_wr <= 0;
    else if (since_wr < SETTLE + 2)
      since_wr <= since_wr + 1;
  end

  // R3: the apply edge is the fifth one after the accepting edge
  p_settle_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (since_wr == SETTLE - 1));

  // R3: ready is never reported while a write is pending
  p_ready_not_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ready |-> !pending_q);

  // R4: a rejected write leaves the running ratio alone
  p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !pending_q) |=> $stable(act_q));

  // R1: the counter stays inside the running ratio
  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != '0) |-> (cnt_q < act_q));

  // R6: an unaligned 4 or 5 produces no high phase
  p_unaligned_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_q == RW'(4) || act_q == RW'(5)) && !synced_q) |-> !pos_q);

  // R7: power-down forces the divider low on the next edge
  p_pwrdn_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !pos_q);
endmodule

bind halfduty_div hd_chk #(.RW(RW), .SETTLE(SETTLE)) chk_i (
  .clk(clk_in), .rst_n(rst_n), .accept(accept), .apply(apply),
  .pending_q(pending_q), .pwr_dn(pwr_dn), .synced_q(synced_q),
  .act_q(act_q), .cnt_q(cnt_q), .pos_q(pos_q), .ratio_ready(ratio_ready)
);

// File: tb/halfduty_div_tb_top.sv
module halfduty_div_tb_top;
  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic       full_chip = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_ratio = 6'd0;
  logic       resync = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       clk_out, ratio_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk_in = ~clk_in;

  halfduty_div dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .full_chip(full_chip), .cfg_wr(cfg_wr),
    .cfg_ratio(cfg_ratio), .resync(resync), .pwr_dn(pwr_dn),
    .clk_out(clk_out), .ratio_ready(ratio_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input bit fc);
    @(negedge clk_in);
    full_chip = fc;
    cfg_ratio = 6'(r);
    cfg_wr    = 1'b1;
    @(negedge clk_in);
    cfg_wr    = 1'b0;
  endtask

  task automatic pulse_rs();
    @(negedge clk_in);
    resync = 1'b1;
    @(negedge clk_in);
    resync = 1'b0;
  endtask

  task automatic sample(output logic v);
    @(clk_in);
    #2;
    v = clk_out;
  endtask

  // measures one output period in half-cycle samples
  task automatic measure(output int hi, output int lo);
    logic prev, cur;
    bit found = 1'b0;
    hi = 0;
    lo = 0;
    sample(cur);
    for (int i = 0; i < 600; i++) begin
      prev = cur;
      sample(cur);
      if (!prev && cur) begin
        found = 1'b1;
        break;
      end
    end
    if (found) begin
      hi = 1;
      for (int i = 0; i < 300; i++) begin
        sample(cur);
        if (!cur) break;
        hi++;
      end
      lo = 1;
      for (int i = 0; i < 300; i++) begin
        sample(cur);
        if (cur) break;
        lo++;
      end
    end
  endtask

  task automatic count_high(input int halves, output int highs);
    logic v;
    highs = 0;
    for (int i = 0; i < halves; i++) begin
      sample(v);
      if (v) highs++;
    end
  endtask

  task automatic check_period(input int n, input string req);
    int hi, lo;
    measure(hi, lo);
    check(hi + lo == 2 * n, {req, " period"}, hi + lo, 2 * n);
    check(hi == n, {req, " high"}, hi, n);
  endtask

  initial begin
    int highs;
    // R8: output low in reset, ratio 2 and ready afterwards
    repeat (3) @(negedge clk_in);
    check(clk_out == 1'b0, "R8 clk_out in reset", int'(clk_out), 0);
    @(negedge clk_in);
    rst_n = 1'b1;
    @(negedge clk_in);
    check(ratio_ready == 1'b1, "R8 ready after reset", int'(ratio_ready), 1);
    check_period(2, "R8");

    // R3: settle window of five edges
    wr(7, 1'b1);
    repeat (4) @(negedge clk_in);
    check(ratio_ready == 1'b0, "R3 ready after E4", int'(ratio_ready), 0);
    @(negedge clk_in);
    check(ratio_ready == 1'b1, "R3 ready after E5", int'(ratio_ready), 1);
    check_period(7, "R3");

    // R4: rejected writes
    wr(1, 1'b1);
    repeat (8) @(negedge clk_in);
    check(ratio_ready == 1'b1, "R4 ready after ratio 1", int'(ratio_ready), 1);
    check_period(7, "R4 ratio 1");
    wr(0, 1'b0);
    repeat (8) @(negedge clk_in);
    check(ratio_ready == 1'b1, "R4 ready after bypass w/o mode", int'(ratio_ready), 1);
    check_period(7, "R4 bypass w/o mode");

    // R5: bypass
    wr(0, 1'b1);
    repeat (6) @(negedge clk_in);
    check_period(1, "R5 bypass");

    // R1 R2 R6: sweep every ratio
    for (int r = 2; r <= 63; r++) begin
      wr(r, 1'b1);
      repeat (6) @(negedge clk_in);
      if (r == 4 || r == 5) begin
        check(ratio_ready == 1'b0, "R6 ready before resync", int'(ratio_ready), 0);
        count_high(4 * r + 4, highs);
        check(highs == 0, "R6 silent before resync", highs, 0);
        pulse_rs();
        check(ratio_ready == 1'b1, "R6 ready after resync", int'(ratio_ready), 1);
        check_period(r, "R6");
      end else begin
        check_period(r, "R1 R2");
      end
    end

    // R7: power-down with ratio 5, then with ratio 7
    wr(5, 1'b1);
    repeat (6) @(negedge clk_in);
    pulse_rs();
    check_period(5, "R7 before pwr_dn");
    @(negedge clk_in);
    pwr_dn = 1'b1;
    @(negedge clk_in);
    count_high(20, highs);
    check(highs == 0, "R7 low in pwr_dn", highs, 0);
    @(negedge clk_in);
    pwr_dn = 1'b0;
    repeat (3) @(negedge clk_in);
    check(ratio_ready == 1'b0, "R7 ratio 5 ready after pwr_dn", int'(ratio_ready), 0);
    count_high(40, highs);
    check(highs == 0, "R7 ratio 5 silent after pwr_dn", highs, 0);
    pulse_rs();
    check(ratio_ready == 1'b1, "R7 ready after resync", int'(ratio_ready), 1);
    check_period(5, "R7 after resync");
    wr(7, 1'b1);
    repeat (6) @(negedge clk_in);
    @(negedge clk_in);
    pwr_dn = 1'b1;
    repeat (5) @(negedge clk_in);
    pwr_dn = 1'b0;
    @(negedge clk_in);
    check(ratio_ready == 1'b1, "R7 ratio 7 ready after pwr_dn", int'(ratio_ready), 1);
    check_period(7, "R7 ratio 7 resumes");

    // R8: reset mid-run returns to ratio 2
    wr(9, 1'b1);
    repeat (6) @(negedge clk_in);
    rst_n = 1'b0;
    repeat (2) @(negedge clk_in);
    check(clk_out == 1'b0, "R8 clk_out mid-run reset", int'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk_in);
    check(ratio_ready == 1'b1, "R8 ready mid-run reset", int'(ratio_ready), 1);
    check_period(2, "R8 mid-run");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(1_500_000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule